// File: doc/BRIEF.md
# Code Prefetch Queue with Bus Arbitration

This block buffers instruction bytes between a shared bus interface and an instruction decoder. It asks the bus for one aligned 32-bit code word whenever the buffer, counting words already requested but not yet returned, has room for one more whole word. The buffer stores bytes in the order the program uses them and hands up to four of them at a time to the decoder. Decoding is not part of the block.

Code fetches have the lowest bus priority. A data access request from the execution side always takes the bus when the bus is ready, so code words move only in otherwise idle bus cycles. Fetching runs on its own and does not follow instruction boundaries. The queue works on words on the bus side and on bytes on the decoder side.

A flush, raised on a taken branch, empties the buffer in one cycle. Words requested before the flush are dropped when they come back. Fetching restarts from the word that holds the branch target, and the bytes of that first word that lie below the target are skipped.

Top module: `code_prefetch_queue`

## Requirements
- R1: After reset the queue holds 0 bytes, the fetch address is RESET_ADDR with its two low bits cleared, and the first word that returns has its lowest RESET_ADDR[1:0] bytes dropped.
- R2: `fetch_req_o` is high exactly when `flush_i` is low, held bytes + 4 × live outstanding words + 4 ≤ 4 × QUEUE_WORDS, and fewer than QUEUE_WORDS fetches (live or cancelled) are outstanding.
- R3: When `bus_ready_i` is high, a pending `data_req_i` takes the bus (`data_gnt_o`). `fetch_gnt_o` is high only when `bus_ready_i` and `fetch_req_o` are high and `data_req_i` is low.
- R4: The fetch address always has its low two bits at zero. After each granted fetch it advances by 4, wrapping at the top of the address space.
- R5: Returned words are appended in return order. Byte k of `fill_data_i` (bits 8k+7:8k) is the byte at word address + k. Byte i of `dec_bytes_o` is the i-th oldest held byte, for i < `dec_avail_o`.
- R6: A take count of 1 to 4 (`take_cnt_i`) that does not exceed `dec_avail_o` raises `take_ok_o` and removes that many bytes at the next edge. A larger count raises `take_stall_o` and removes nothing. A count of 0 does nothing.
- R7: A flush makes `dec_avail_o` 0 in the next cycle and loads the fetch address with the target with its low two bits cleared. Every fetch granted before the flush is dropped when it returns.
- R8: The first word kept after a flush drops its lowest target[1:0] bytes, so the first byte offered is the byte at the target address.
- R9: The queue never holds more than 4 × QUEUE_WORDS bytes. When it is full, no fetch is requested.
- R10: In a flush cycle, a returning word and a take request have no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Branch flush |
| flush_target_i | input | ADDR_W | Branch target byte address |
| data_req_i | input | 1 | Data access pending from the execution side |
| bus_ready_i | input | 1 | Bus can accept one access this cycle |
| data_gnt_o | output | 1 | Data access granted this cycle |
| fetch_req_o | output | 1 | Code fetch wanted (space for a whole word) |
| fetch_gnt_o | output | 1 | Code fetch issued this cycle |
| fetch_addr_o | output | ADDR_W | Word-aligned code fetch address |
| fill_valid_i | input | 1 | A code word returns this cycle (in request order) |
| fill_data_i | input | 32 | Returned code word, lowest address in bits 7:0 |
| take_cnt_i | input | 3 | Bytes the decoder wants to take (0 to 4) |
| take_ok_o | output | 1 | Take accepted |
| take_stall_o | output | 1 | Take refused, too few bytes held |
| dec_bytes_o | output | 32 | Four oldest held bytes, oldest in bits 7:0 |
| dec_avail_o | output | $clog2(4·QUEUE_WORDS+1) | Number of bytes held |

## Verification
The bench builds the block with QUEUE_WORDS = 4, ADDR_W = 16 and RESET_ADDR = 0x0101. A bus model in the bench returns each code word two cycles after its grant. The 16-byte queue fills and drains within a few cycles, so every take count meets empty, partial and full states many times. The short address lets one branch target land near the top of the space, where the fetch address wraps. The sweep covers all four target byte offsets, every take count, four bus-ready patterns and both data-request patterns, and it flushes while words are still in flight.

// File: rtl/pfq_pkg.sv
// Shared definitions for the code prefetch queue.
// Assumes: bus words are 32 bits wide and made of four byte lanes.
package pfq_pkg;

    localparam int LANES = 4;

    // Who owns the bus in the current cycle.
    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_DATA = 2'd1,
        BUS_CODE = 2'd2
    } bus_owner_e;

    // Pick one byte lane out of a bus word.
    function automatic logic [7:0] lane_pick(input logic [31:0] w, input int sel);
        logic [31:0] s;
        s = w >> (8 * sel);
        return s[7:0];
    endfunction

endpackage

// File: rtl/pfq_arbiter.sv
// Fixed-priority bus arbiter: a data access always beats a code fetch.
// Assumes: at most one access is issued per cycle, and only while the bus is ready.
module pfq_arbiter
    import pfq_pkg::*;
(
    input  logic bus_ready_i,
    input  logic data_req_i,
    input  logic code_req_i,
    output logic data_gnt_o,
    output logic code_gnt_o
);

    bus_owner_e owner;

    // Decide the owner of this bus cycle.
    always_comb begin
        owner = BUS_IDLE;
        if (bus_ready_i) begin
            if (data_req_i) begin
                owner = BUS_DATA;
            end else if (code_req_i) begin
                owner = BUS_CODE;
            end
        end
    end

    assign data_gnt_o = (owner == BUS_DATA);
    assign code_gnt_o = (owner == BUS_CODE);

endmodule

// File: rtl/pfq_fetch_ctl.sv
// Fetch controller: holds the fetch address, counts live and cancelled
// in-flight words, and tells the buffer which returned words to keep.
// Assumes: words return in grant order; no grant is made in a flush cycle.
module pfq_fetch_ctl #(
    parameter int                ADDR_W      = 32,
    parameter int                QUEUE_WORDS = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR  = '0,
    localparam int               CW          = $clog2(QUEUE_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              code_gnt_i,
    input  logic              fill_valid_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [CW-1:0]     inflight_o,
    output logic [CW-1:0]     outstanding_o,
    output logic              fill_keep_o,
    output logic [1:0]        fill_skip_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [CW-1:0]     inflight_q;
    logic [CW-1:0]     discard_q;
    logic [1:0]        skip_q;
    logic              ret_live;
    logic              ret_dead;

    // Classify a returning word: the cancelled ones come back first.
    always_comb begin
        ret_dead = fill_valid_i && (discard_q != '0);
        ret_live = fill_valid_i && (discard_q == '0);
    end

    assign fill_keep_o   = ret_live && !flush_i;
    assign fill_skip_o   = skip_q;
    assign fetch_addr_o  = addr_q;
    assign inflight_o    = inflight_q;
    assign outstanding_o = inflight_q + discard_q;

    // Address, in-flight bookkeeping and pending byte skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= {RESET_ADDR[ADDR_W-1:2], 2'b00};
            inflight_q <= '0;
            discard_q  <= '0;
            skip_q     <= RESET_ADDR[1:0];
        end else if (flush_i) begin
            addr_q     <= {target_i[ADDR_W-1:2], 2'b00};
            discard_q  <= discard_q + inflight_q - CW'(fill_valid_i);
            inflight_q <= '0;
            skip_q     <= target_i[1:0];
        end else begin
            if (code_gnt_i) begin
                addr_q <= addr_q + ADDR_W'(4);
            end
            inflight_q <= inflight_q + CW'(code_gnt_i) - CW'(ret_live);
            discard_q  <= discard_q - CW'(ret_dead);
            if (ret_live) begin
                skip_q <= 2'b00;
            end
        end
    end

endmodule

// File: rtl/pfq_byte_ring.sv
// Byte ring buffer: takes in a word (minus skipped low bytes) at the tail
// and offers four bytes at the head to the decoder.
// Assumes: the caller reserves space before writing and never removes
// more bytes than are held.
module pfq_byte_ring
    import pfq_pkg::*;
#(
    parameter int  QUEUE_WORDS = 4,
    localparam int QB          = QUEUE_WORDS * LANES,
    localparam int LW          = $clog2(QB + 1),
    localparam int PW          = (QB > 1) ? $clog2(QB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          wr_en_i,
    input  logic [31:0]   wr_word_i,
    input  logic [1:0]    wr_skip_i,
    input  logic [2:0]    rd_cnt_i,
    output logic [LW-1:0] level_o,
    output logic [31:0]   head_bytes_o
);

    logic [7:0]    mem_q [QB];
    logic [PW-1:0] head_q;
    logic [PW-1:0] tail_q;
    logic [LW-1:0] level_q;
    logic [2:0]    wlen;

    // Wrap a byte position into the ring.
    function automatic logic [PW-1:0] wrap(input int unsigned v);
        int unsigned r;
        r = v % QB;
        return PW'(r);
    endfunction

    // Bytes actually stored from this write.
    assign wlen = wr_en_i ? (3'd4 - {1'b0, wr_skip_i}) : 3'd0;

    // Store the kept lanes of the incoming word at consecutive tail slots.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (wr_en_i && (3'(k) < wlen)) begin
                mem_q[wrap(32'(tail_q) + 32'(k))] <= lane_pick(wr_word_i, k + int'(wr_skip_i));
            end
        end
    end

    // Move head, tail and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            head_q  <= '0;
            tail_q  <= '0;
            level_q <= '0;
        end else begin
            head_q  <= wrap(32'(head_q) + 32'(rd_cnt_i));
            tail_q  <= wrap(32'(tail_q) + 32'(wlen));
            level_q <= level_q + LW'(wlen) - LW'(rd_cnt_i);
        end
    end

    assign level_o = level_q;

    // Offer the four oldest bytes. Lanes beyond the fill level read as zero.
    for (genvar i = 0; i < LANES; i++) begin : g_head_lane
        assign head_bytes_o[8*i +: 8] = (32'(level_q) > 32'(i))
                                        ? mem_q[wrap(32'(head_q) + 32'(i))] : 8'h00;
    end

endmodule

// File: rtl/code_prefetch_queue.sv
// Code prefetch queue top: joins the fetch controller, the bus arbiter and
// the byte ring. It requests a code word when a whole word of space is free,
// counting words still in flight.
// Assumes: the bus returns code words in grant order, one per cycle at most.
module code_prefetch_queue #(
    parameter int                ADDR_W      = 32,
    parameter int                QUEUE_WORDS = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR  = '0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 flush_i,
    input  logic [ADDR_W-1:0]                    flush_target_i,
    input  logic                                 data_req_i,
    input  logic                                 bus_ready_i,
    output logic                                 data_gnt_o,
    output logic                                 fetch_req_o,
    output logic                                 fetch_gnt_o,
    output logic [ADDR_W-1:0]                    fetch_addr_o,
    input  logic                                 fill_valid_i,
    input  logic [31:0]                          fill_data_i,
    input  logic [2:0]                           take_cnt_i,
    output logic                                 take_ok_o,
    output logic                                 take_stall_o,
    output logic [31:0]                          dec_bytes_o,
    output logic [$clog2(QUEUE_WORDS*4+1)-1:0]   dec_avail_o
);

    localparam int QB = QUEUE_WORDS * 4;
    localparam int LW = $clog2(QB + 1);
    localparam int CW = $clog2(QUEUE_WORDS + 1);

    logic [LW-1:0] level;
    logic [CW-1:0] inflight;
    logic [CW-1:0] outstanding;
    logic          fill_keep;
    logic [1:0]    fill_skip;
    logic          space_ok;
    logic          slots_ok;
    logic [2:0]    rd_cnt;

    // Space for one more whole word after every live in-flight word lands.
    always_comb begin
        space_ok = (32'(level) + 32'(inflight) * 4 + 32'd4) <= 32'(QB);
        slots_ok = 32'(outstanding) < 32'(QUEUE_WORDS);
    end

    assign fetch_req_o = !flush_i && space_ok && slots_ok;

    // Accept a take of 1 to 4 bytes when enough bytes are held.
    always_comb begin
        take_ok_o    = !flush_i && (take_cnt_i != 3'd0) && (take_cnt_i <= 3'd4)
                       && (32'(take_cnt_i) <= 32'(level));
        take_stall_o = !flush_i && (take_cnt_i != 3'd0) && !take_ok_o;
        rd_cnt       = take_ok_o ? take_cnt_i : 3'd0;
    end

    pfq_arbiter u_arb (
        .bus_ready_i (bus_ready_i),
        .data_req_i  (data_req_i),
        .code_req_i  (fetch_req_o),
        .data_gnt_o  (data_gnt_o),
        .code_gnt_o  (fetch_gnt_o)
    );

    pfq_fetch_ctl #(
        .ADDR_W      (ADDR_W),
        .QUEUE_WORDS (QUEUE_WORDS),
        .RESET_ADDR  (RESET_ADDR)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .target_i      (flush_target_i),
        .code_gnt_i    (fetch_gnt_o),
        .fill_valid_i  (fill_valid_i),
        .fetch_addr_o  (fetch_addr_o),
        .inflight_o    (inflight),
        .outstanding_o (outstanding),
        .fill_keep_o   (fill_keep),
        .fill_skip_o   (fill_skip)
    );

    pfq_byte_ring #(
        .QUEUE_WORDS (QUEUE_WORDS)
    ) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .wr_en_i      (fill_keep),
        .wr_word_i    (fill_data_i),
        .wr_skip_i    (fill_skip),
        .rd_cnt_i     (rd_cnt),
        .level_o      (level),
        .head_bytes_o (dec_bytes_o)
    );

    assign dec_avail_o = level;

endmodule

// File: rtl/pfq_checker.sv
// Property checker for the code prefetch queue, bound to the top module.
// Assumes: reset is synchronous and active low.
module pfq_checker #(
    parameter int  ADDR_W      = 32,
    parameter int  QUEUE_WORDS = 4,
    localparam int QB          = QUEUE_WORDS * 4,
    localparam int LW          = $clog2(QB + 1),
    localparam int CW          = $clog2(QUEUE_WORDS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              data_req_i,
    input logic              fetch_req_o,
    input logic              fetch_gnt_o,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic              take_stall_o,
    input logic [LW-1:0]     dec_avail_o,
    input logic [CW-1:0]     inflight_i
);

    AST_CODE_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        data_req_i |-> !fetch_gnt_o);                                             // R3
    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_gnt_o |-> fetch_req_o);                                             // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_gnt_o |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(4));        // R4
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr_o[1:0] == 2'b00);                                              // R4
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> dec_avail_o == '0);                                           // R7
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_stall_o && !flush_i) |=> dec_avail_o >= $past(dec_avail_o));      // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(dec_avail_o) + 32'(inflight_i) * 4) <= 32'(QB));                    // R9

endmodule

bind code_prefetch_queue pfq_checker #(
    .ADDR_W      (ADDR_W),
    .QUEUE_WORDS (QUEUE_WORDS)
) u_pfq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .data_req_i   (data_req_i),
    .fetch_req_o  (fetch_req_o),
    .fetch_gnt_o  (fetch_gnt_o),
    .fetch_addr_o (fetch_addr_o),
    .take_stall_o (take_stall_o),
    .dec_avail_o  (dec_avail_o),
    .inflight_i   (inflight)
);

// File: tb/test_code_prefetch_queue.sv
// Self-checking bench: a bus model returns code words two cycles after the
// grant; a byte-level model predicts fill level, bytes, grants and address.
module test_code_prefetch_queue;

    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 16;
    localparam int          QW         = 4;
    localparam int          QB         = QW * 4;
    localparam int          LAT        = 2;
    localparam logic [15:0] RST_ADDR   = 16'h0101;
    localparam int          AMASK      = 16'hFFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_i = 1'b0;
    logic [ADDR_W-1:0] flush_target_i = '0;
    logic              data_req_i = 1'b0;
    logic              bus_ready_i = 1'b0;
    logic              data_gnt_o;
    logic              fetch_req_o;
    logic              fetch_gnt_o;
    logic [ADDR_W-1:0] fetch_addr_o;
    logic              fill_valid_i = 1'b0;
    logic [31:0]       fill_data_i = '0;
    logic [2:0]        take_cnt_i = '0;
    logic              take_ok_o;
    logic              take_stall_o;
    logic [31:0]       dec_bytes_o;
    logic [4:0]        dec_avail_o;

    code_prefetch_queue #(
        .ADDR_W      (ADDR_W),
        .QUEUE_WORDS (QW),
        .RESET_ADDR  (RST_ADDR)
    ) i_code_prefetch_queue (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Model state.
    int    exp_avail = 0;
    int    exp_head = int'(RST_ADDR);
    int    exp_fetch = int'(RST_ADDR) & 16'hFFFC;
    int    pend_skip = int'(RST_ADDR[1:0]);
    bit    pv [LAT];
    bit    pl [LAT];
    int    pa [LAT];
    string tag = "R5";
    int    max_avail = 0;
    int    stalls = 0;
    int    drops = 0;

    function automatic logic [7:0] pat(input int a);
        int m;
        m = a & AMASK;
        return 8'((m * 29 + (m >> 8) * 7 + 3) & 255);
    endfunction

    function automatic logic [31:0] word_at(input int a);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[8*k +: 8] = pat(a + k);
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One clock cycle, entered and left at a falling edge.
    task automatic step(input bit fl, input int tgt, input bit dr, input bit br, input int cnt);
        int  live;
        int  valid;
        bit  exp_req;
        bit  exp_ok;
        bit  dlv;
        bit  used;
        bit  gnt;
        int  gaddr;
        // Held state from the previous edge.
        chk(int'(dec_avail_o) == exp_avail, tag, int'(dec_avail_o), exp_avail);
        for (int i = 0; i < 4; i++) begin
            if (i < exp_avail)
                chk(dec_bytes_o[8*i +: 8] == pat(exp_head + i), tag,
                    int'(dec_bytes_o[8*i +: 8]), int'(pat(exp_head + i)));
        end
        if (exp_avail > max_avail) max_avail = exp_avail;
        // Drive this cycle.
        dlv            = pv[LAT-1];
        flush_i        = fl;
        flush_target_i = ADDR_W'(tgt);
        data_req_i     = dr;
        bus_ready_i    = br;
        take_cnt_i     = 3'(cnt);
        fill_valid_i   = dlv;
        fill_data_i    = dlv ? word_at(pa[LAT-1]) : 32'h0;
        #1;
        live = 0;
        valid = 0;
        for (int i = 0; i < LAT; i++) begin
            if (pv[i]) valid++;
            if (pv[i] && pl[i]) live++;
        end
        exp_req = !fl && (exp_avail + 4 * live + 4 <= QB) && (valid < QW);
        chk(fetch_req_o == exp_req, "R2", int'(fetch_req_o), int'(exp_req));
        if (exp_avail == QB) chk(!fetch_req_o, "R9", int'(fetch_req_o), 0);
        chk(fetch_gnt_o == (exp_req && br && !dr), "R3", int'(fetch_gnt_o), int'(exp_req && br && !dr));
        chk(data_gnt_o == (dr && br), "R3", int'(data_gnt_o), int'(dr && br));
        chk(int'(fetch_addr_o) == exp_fetch, "R4", int'(fetch_addr_o), exp_fetch);
        exp_ok = !fl && cnt >= 1 && cnt <= 4 && cnt <= exp_avail;
        chk(take_ok_o == exp_ok, "R6", int'(take_ok_o), int'(exp_ok));
        chk(take_stall_o == (!fl && cnt != 0 && !exp_ok), "R6", int'(take_stall_o), int'(!fl && cnt != 0 && !exp_ok));
        if (take_stall_o) stalls++;
        gnt = fetch_gnt_o;
        gaddr = int'(fetch_addr_o);
        // Advance the model.
        if (fl) begin
            tag = (cnt != 0 || dlv) ? "R10" : "R7";
            if (dlv) drops++;
            exp_avail = 0;
            exp_head = tgt & AMASK;
            pend_skip = tgt & 3;
            exp_fetch = tgt & 16'hFFFC;
            for (int i = 0; i < LAT; i++) pl[i] = 1'b0;
        end else begin
            used = dlv && pl[LAT-1];
            if (dlv && !pl[LAT-1]) drops++;
            tag = (used && pend_skip != 0) ? "R8" : (exp_ok ? "R6" : "R5");
            if (exp_ok) begin
                exp_avail -= cnt;
                exp_head = (exp_head + cnt) & AMASK;
            end
            if (used) begin
                exp_avail += 4 - pend_skip;
                pend_skip = 0;
            end
            if (gnt) exp_fetch = (exp_fetch + 4) & AMASK;
        end
        for (int i = LAT - 1; i > 0; i--) begin
            pv[i] = pv[i-1];
            pl[i] = pl[i-1];
            pa[i] = pa[i-1];
        end
        pv[0] = gnt;
        pl[0] = gnt;
        pa[0] = gaddr;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        cyc = 0;
        for (int i = 0; i < LAT; i++) begin
            pv[i] = 1'b0;
            pl[i] = 1'b0;
            pa[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        chk(dec_avail_o == 5'd0, "R1", int'(dec_avail_o), 0);
        chk(fetch_addr_o == 16'h0100, "R1", int'(fetch_addr_o), 16'h0100);
        chk(fetch_req_o == 1'b1, "R1", int'(fetch_req_o), 1);
        chk(take_ok_o == 1'b0, "R1", int'(take_ok_o), 0);
        @(negedge clk);
        // R1/R9: fill from the reset address with no takes until full.
        tag = "R1";
        for (int n = 0; n < 12; n++) step(1'b0, 0, 1'b0, 1'b1, 0);
        // R6: drain with maximal takes, running into stalls.
        for (int n = 0; n < 6; n++) step(1'b0, 0, 1'b0, 1'b0, 4);
        // Sweep target offsets, data patterns, ready patterns and take patterns.
        for (int off = 0; off < 4; off++) begin
            for (int dm = 0; dm < 2; dm++) begin
                for (int bm = 0; bm < 4; bm++) begin
                    for (int cp = 0; cp < 6; cp++) begin
                        int tgt;
                        tgt = (16'h2000 + 64 * (off * 48 + dm * 24 + bm * 6 + cp) + off) & AMASK;
                        if (off == 3 && dm == 1 && bm == 3 && cp == 5) tgt = 16'hFFF9;
                        step(1'b1, tgt, 1'b0, 1'b1, cp % 5);
                        for (int n = 0; n < 12; n++) begin
                            bit dr;
                            bit br;
                            int cnt;
                            cyc++;
                            dr = (dm == 1) && (cyc % 3 == 0);
                            case (bm)
                                0: br = 1'b1;
                                1: br = (cyc % 2 == 0);
                                2: br = (cyc % 3 != 1);
                                default: br = (n < 6);
                            endcase
                            cnt = (cp < 5) ? cp : (cyc * 3) % 6;
                            step(1'b0, 0, dr, br, cnt);
                        end
                    end
                end
            end
        end
        // Let the wrapped-address run progress, then drain.
        for (int n = 0; n < 20; n++) step(1'b0, 0, 1'b0, 1'b1, (n % 4) + 1);
        chk(max_avail == QB, "R9", max_avail, QB);
        chk(stalls > 0, "R6", stalls, 1);
        chk(drops > 0, "R7", drops, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule